// File: doc/BRIEF.md
# Dock Condition and Loop-Count Unit

This block keeps the condition state of one dock in a switch-fabric processor: two general-purpose flags (A and B), a control flag (C), a predicate flag (P), a zero indication (Z) and a 37-bit loop counter. A sequencer that has already decoded each instruction drives this unit with command strobes and fields. The unit returns the flags and an execute-enable.

The execute-enable states whether the instruction now offered may run. An instruction marked unconditional always runs. Any other instruction runs only while P is set. A flag-update command forms the new A and new B independently. For each one, a six-bit selection mask picks some of the literals A, not-A, B, not-B, C and not-C, and the picked literals are ORed together. A move updates C from the packet signal bit or from the ship. The loop counter is loaded from the full data latch, or counts down by one. P clears itself when a torpedo strikes, and also when a decrement takes the counter to zero.

Top module: `dock_cond_unit`

## Requirements
- R1: A synchronous reset (`rst`=1 at a clock edge) clears A, B, C, P and the counter, so Z reads 1 after the reset.
- R2: `flag_z` is 1 exactly when `lc_value` is zero, in the same cycle. No extra register stage sits between them.
- R3: When `torpedo_strike` is high at an edge, P is 0 after that edge. This holds even if a P write with value 1 arrives in the same cycle.
- R4: `exec_en` is 1 only when `instr_valid` is 1 and either `instr_uncond` is 1 or P is 1.
- R5: When `flag_upd` is high, new A is the OR of the literals that `next_a_sel` selects, and new B is the OR of the literals that `next_b_sel` selects. The mask bits select: bit 5 A, bit 4 not-A, bit 3 B, bit 2 not-B, bit 1 C, bit 0 not-C. C is not changed by this command.
- R6: An all-zero mask yields 0. A mask that selects a flag together with its complement yields 1. A mask that selects each flag as itself (A for A, B for B) leaves both flags unchanged.
- R7: Both new values are computed from the A, B and C present before the edge. For example, masks selecting B for A and A for B swap the two flags.
- R8: When `move_strobe` is high, C is set as follows. At an input dock (`dock_is_input`=1), C takes `pkt_signal`. At an output dock with `dc_bit`=1, C takes `ship_c`. At an output dock with `dc_bit`=0, C takes `pkt_signal`.
- R9: `lc_load` copies all 37 bits of `lc_data` into the counter. If `lc_dec` arrives in the same cycle, the load wins.
- R10: `lc_dec` without a load lowers a nonzero counter by one. A decrement from 1 to 0 also clears P.
- R11: `lc_dec` while the counter is already zero leaves it at zero and does not clear P.
- R12: `p_wr` writes `p_val` into P, unless a torpedo strike or a decrement to zero clears P in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | An instruction is offered for execution |
| instr_uncond | input | 1 | Unconditional bit of the offered instruction |
| exec_en | output | 1 | The offered instruction may execute |
| flag_upd | input | 1 | Apply the flag-update command |
| next_a_sel | input | 6 | Literal selection mask for the new A |
| next_b_sel | input | 6 | Literal selection mask for the new B |
| p_wr | input | 1 | Write P |
| p_val | input | 1 | Value written to P |
| move_strobe | input | 1 | A move executes this cycle |
| dock_is_input | input | 1 | 1 at an input dock, 0 at an output dock |
| dc_bit | input | 1 | Data-capture bit of the move |
| pkt_signal | input | 1 | Signal bit of the packet |
| ship_c | input | 1 | Control value offered by the ship |
| lc_load | input | 1 | Load the counter from the data latch |
| lc_data | input | 37 | Data latch contents |
| lc_dec | input | 1 | Decrement the counter |
| torpedo_strike | input | 1 | A torpedo has struck |
| flag_a | output | 1 | Flag A |
| flag_b | output | 1 | Flag B |
| flag_c | output | 1 | Control flag C |
| flag_p | output | 1 | Predicate flag P |
| flag_z | output | 1 | Counter-is-zero indication |
| lc_value | output | 37 | Loop counter |

## Verification
The assertions assume that every command input is a known 0 or 1 at each clock edge. They also assume that each strobe means exactly what it says, with no further gating by `exec_en`. Several commands may therefore land in the same cycle, and the clearing properties rely on that.

The stimulus changes inputs only just after a rising edge and returns every strobe to 0 between operations. The exception is the collision tests, which raise two commands together on purpose: load with decrement, and strike with a P write. This keeps the load-priority and clear-priority properties within their assumptions.

// File: rtl/dock_cond_pkg.sv
package dock_cond_pkg;
  localparam int SEL_W = 6;

  // Literal vector in mask order: A, ~A, B, ~B, C, ~C (bit 5 down to bit 0).
  function automatic logic [SEL_W-1:0] literal_vec(input logic a, input logic b, input logic c);
    return {a, ~a, b, ~b, c, ~c};
  endfunction

  // New flag value: OR of the selected literals.
  function automatic logic select_or(input logic [SEL_W-1:0] sel,
                                     input logic a, input logic b, input logic c);
    return |(sel & literal_vec(a, b, c));
  endfunction

  // Source of C on a move.
  function automatic logic c_source(input logic is_in, input logic dc,
                                    input logic sig, input logic ship);
    return (!is_in && dc) ? ship : sig;
  endfunction
endpackage

// File: rtl/dock_flag_eval.sv
module dock_flag_eval
  import dock_cond_pkg::*;
(
  input  logic             cur_a,
  input  logic             cur_b,
  input  logic             cur_c,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_b,
  output logic             new_a,
  output logic             new_b
);
  // Both results use the same snapshot of the old flags.
  always_comb begin
    new_a = select_or(sel_a, cur_a, cur_b, cur_c);
    new_b = select_or(sel_b, cur_a, cur_b, cur_c);
  end
endmodule

// File: rtl/dock_loop_ctr.sv
module dock_loop_ctr #(
  parameter int W = 37
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         is_zero,
  output logic         hit_zero
);
  localparam logic [W-1:0] ONE = W'(1);

  logic dec_live;

  assign is_zero  = (count == '0);
  assign dec_live = dec && !load && !is_zero;
  assign hit_zero = dec_live && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (load)     count <= load_val;
    else if (dec_live) count <= count - ONE;
  end

  a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val));
  a_r11_hold_at_zero: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && count == '0) |=> count == '0);
  a_r10_dec_by_one: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && count != '0) |=> count == $past(count) - ONE);
endmodule

// File: rtl/dock_cond_unit.sv
module dock_cond_unit
  import dock_cond_pkg::*;
#(
  parameter int LC_W = 37
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic            instr_uncond,
  output logic            exec_en,
  input  logic            flag_upd,
  input  logic [5:0]      next_a_sel,
  input  logic [5:0]      next_b_sel,
  input  logic            p_wr,
  input  logic            p_val,
  input  logic            move_strobe,
  input  logic            dock_is_input,
  input  logic            dc_bit,
  input  logic            pkt_signal,
  input  logic            ship_c,
  input  logic            lc_load,
  input  logic [LC_W-1:0] lc_data,
  input  logic            lc_dec,
  input  logic            torpedo_strike,
  output logic            flag_a,
  output logic            flag_b,
  output logic            flag_c,
  output logic            flag_p,
  output logic            flag_z,
  output logic [LC_W-1:0] lc_value
);
  logic a_q, b_q, c_q, p_q;
  logic upd_a, upd_b;
  logic ctr_zero, ctr_hit_zero;
  logic p_clear_evt;

  dock_flag_eval u_eval (
    .cur_a (a_q), .cur_b (b_q), .cur_c (c_q),
    .sel_a (next_a_sel), .sel_b (next_b_sel),
    .new_a (upd_a), .new_b (upd_b)
  );

  dock_loop_ctr #(.W(LC_W)) u_ctr (
    .clk (clk), .rst (rst),
    .load (lc_load), .load_val (lc_data), .dec (lc_dec),
    .count (lc_value), .is_zero (ctr_zero), .hit_zero (ctr_hit_zero)
  );

  assign p_clear_evt = torpedo_strike || ctr_hit_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      c_q <= 1'b0;
      p_q <= 1'b0;
    end else begin
      if (flag_upd) begin
        a_q <= upd_a;
        b_q <= upd_b;
      end
      if (move_strobe)
        c_q <= c_source(dock_is_input, dc_bit, pkt_signal, ship_c);
      if (p_clear_evt) p_q <= 1'b0;
      else if (p_wr)   p_q <= p_val;
    end
  end

  assign exec_en = instr_valid && (instr_uncond || p_q);
  assign flag_a  = a_q;
  assign flag_b  = b_q;
  assign flag_c  = c_q;
  assign flag_p  = p_q;
  assign flag_z  = ctr_zero;

  a_r3_strike_clears_p: assert property (@(posedge clk) disable iff (rst)
    torpedo_strike |=> !flag_p);
  a_r4_gated_by_p: assert property (@(posedge clk) disable iff (rst)
    (!instr_uncond && !flag_p) |-> !exec_en);
  a_r10_zero_clears_p: assert property (@(posedge clk) disable iff (rst)
    (lc_dec && !lc_load && lc_value == LC_W'(1)) |=> !flag_p);
  a_r2_load_zero_sets_z: assert property (@(posedge clk) disable iff (rst)
    (lc_load && lc_data == '0) |=> flag_z);
  a_r6_empty_mask_zero: assert property (@(posedge clk) disable iff (rst)
    (flag_upd && next_a_sel == 6'd0) |=> !flag_a);
  a_r6_pair_gives_one: assert property (@(posedge clk) disable iff (rst)
    (flag_upd && next_b_sel[3] && next_b_sel[2]) |=> flag_b);
  a_r5_c_kept_on_update: assert property (@(posedge clk) disable iff (rst)
    (flag_upd && !move_strobe) |=> $stable(flag_c));
endmodule

// File: tb/tb_dock_cond_unit.sv
module tb_dock_cond_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 37;
  localparam int NV = 8;
  // {a0,b0,c0, mask_a[6], mask_b[6], exp_a, exp_b}
  localparam logic [16:0] VEC [NV] = '{
    {3'b101, 6'b000000, 6'b000000, 2'b00},
    {3'b101, 6'b100000, 6'b001000, 2'b10},
    {3'b010, 6'b110000, 6'b000011, 2'b11},
    {3'b100, 6'b001000, 6'b100000, 2'b01},
    {3'b001, 6'b000010, 6'b000001, 2'b10},
    {3'b110, 6'b010100, 6'b000101, 2'b01},
    {3'b011, 6'b011000, 6'b100010, 2'b11},
    {3'b111, 6'b010101, 6'b000000, 2'b00}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic instr_valid, instr_uncond, exec_en, flag_upd, p_wr, p_val;
  logic [5:0] next_a_sel, next_b_sel;
  logic move_strobe, dock_is_input, dc_bit, pkt_signal, ship_c;
  logic lc_load, lc_dec, torpedo_strike;
  logic [W-1:0] lc_data, lc_value;
  logic flag_a, flag_b, flag_c, flag_p, flag_z;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dock_cond_unit dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    instr_valid = 0; instr_uncond = 0; flag_upd = 0; p_wr = 0; p_val = 0;
    next_a_sel = 0; next_b_sel = 0; move_strobe = 0; dock_is_input = 1;
    dc_bit = 0; pkt_signal = 0; ship_c = 0; lc_load = 0; lc_dec = 0;
    torpedo_strike = 0; lc_data = '0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic preset(input logic a, input logic b, input logic c);
    flag_upd = 1; next_a_sel = a ? 6'b110000 : 6'b0; next_b_sel = b ? 6'b001100 : 6'b0;
    move_strobe = 1; dock_is_input = 1; pkt_signal = c;
    step();
  endtask

  task automatic set_p(input logic v);
    p_wr = 1; p_val = v; step();
  endtask

  task automatic load_ctr(input logic [W-1:0] v);
    lc_load = 1; lc_data = v; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 flags", {flag_a, flag_b, flag_c, flag_p}, 4'b0000);
    chk("R1 counter", lc_value, 0);
    chk("R1 z", flag_z, 1);
    rst = 0;

    // R5 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      preset(VEC[i][16], VEC[i][15], VEC[i][14]);
      flag_upd = 1; next_a_sel = VEC[i][13:8]; next_b_sel = VEC[i][7:2];
      step();
      chk($sformatf("R5/R6/R7 vec%0d a", i), flag_a, VEC[i][1]);
      chk($sformatf("R5/R6/R7 vec%0d b", i), flag_b, VEC[i][0]);
      chk($sformatf("R5 vec%0d c kept", i), flag_c, VEC[i][14]);
    end

    // R8 C sources
    move_strobe = 1; dock_is_input = 0; dc_bit = 1; ship_c = 1; pkt_signal = 0; step();
    chk("R8 output dc ship", flag_c, 1);
    move_strobe = 1; dock_is_input = 0; dc_bit = 0; ship_c = 1; pkt_signal = 0; step();
    chk("R8 output no dc signal", flag_c, 0);
    move_strobe = 1; dock_is_input = 1; dc_bit = 1; ship_c = 0; pkt_signal = 1; step();
    chk("R8 input signal", flag_c, 1);

    // R12 and R4
    set_p(1);
    chk("R12 p set", flag_p, 1);
    instr_valid = 1; instr_uncond = 0; #1;
    chk("R4 cond with p", exec_en, 1);
    set_p(0);
    chk("R12 p clear", flag_p, 0);
    instr_valid = 1; instr_uncond = 0; #1;
    chk("R4 cond no p", exec_en, 0);
    instr_uncond = 1; #1;
    chk("R4 uncond", exec_en, 1);
    instr_valid = 0; #1;
    chk("R4 no valid", exec_en, 0);
    idle();

    // R3 strike beats write
    set_p(1);
    torpedo_strike = 1; p_wr = 1; p_val = 1; step();
    chk("R3 strike clears p", flag_p, 0);

    // R9 full-width load, load beats decrement; R2
    load_ctr({1'b1, 35'h0, 1'b1});
    chk("R9 load", lc_value, {1'b1, 35'h0, 1'b1});
    chk("R2 z nonzero", flag_z, 0);
    lc_load = 1; lc_data = 37'd2; lc_dec = 1; step();
    chk("R9 load wins", lc_value, 2);

    // R10 decrement and clear on zero
    set_p(1);
    lc_dec = 1; step();
    chk("R10 dec value", lc_value, 1);
    chk("R10 p kept above zero", flag_p, 1);
    lc_dec = 1; step();
    chk("R10 dec to zero", lc_value, 0);
    chk("R10 p cleared", flag_p, 0);
    chk("R2 z at zero", flag_z, 1);

    // R11 decrement at zero
    set_p(1);
    lc_dec = 1; step();
    chk("R11 stays zero", lc_value, 0);
    chk("R11 p kept", flag_p, 1);

    // R1 reset again from busy state
    load_ctr(37'd5);
    rst = 1; step(); rst = 0;
    chk("R1 re-reset counter", lc_value, 0);
    chk("R1 re-reset p", flag_p, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule